// File: doc/BRIEF.md
# Serial Flash Auto-Increment Program Decoder

This block is the device-side command logic of a serial flash that accepts bytes over a four-wire SPI link (mode 0). It decodes four commands from the serial input: write enable, write disable, status read, and the auto-increment program command. It keeps the write-enable latch, a busy flag and an internal address pointer. It sends byte-write requests to an external behavioural memory array. SCK, chip select and serial data arrive already synchronous to the system clock. The block finds SCK edges by comparing each sample with the one before.

Auto-increment programming spans several chip-select frames. The first program frame carries the opcode AFh, a 24-bit start address (most significant byte first) and one data byte. After it, the block is in auto-increment mode, and each later AFh frame carries the opcode and one data byte only. That byte goes to the address one above the previous one. Each accepted byte starts a program cycle when chip select goes high. During the cycle the busy flag stays set for a number of clocks given on an input. An input boundary address marks the highest unprotected location. A start above it is refused. Once the boundary address has been written, the mode ends and the write-enable latch clears, so the address never wraps.

Top module: `aai_flash_ctrl`

## Requirements
- R1: Opcode 06h in a frame of exactly one byte sets the write-enable latch. An AFh frame that ends while the latch is clear writes nothing.
- R2: Outside auto-increment mode, a frame of opcode AFh, three address bytes (high byte first) and one data byte writes at that address and enters auto-increment mode.
- R3: In auto-increment mode, a frame of opcode AFh and exactly one data byte writes at the address one above the previously written one.
- R4: An accepted byte is requested on `mem_we` in the first clock after chip select rises. `busy` rises in the next clock and stays high for exactly `prog_cycles` clocks.
- R5: Opcode 04h in a frame of exactly one byte clears the write-enable latch and ends auto-increment mode.
- R6: A first AFh frame whose address is above `top_addr` writes nothing and leaves the latch and the mode unchanged.
- R7: After the byte at `top_addr` is written, the mode ends and the latch clears. No write ever targets an address above `top_addr`.
- R8: After opcode 05h, the status byte is shifted out on `miso` MSB first, changing on SCK falling edges, and is refreshed every byte, including while busy. Bit 0 is busy, bit 1 is the write-enable latch, and the other bits are 0.
- R9: A frame that ends with a partial byte, and an AFh frame that ends while busy, are discarded without moving the address pointer.
- R10: The written value is the stored byte ANDed with the new data byte, so bits only go from 1 to 0.
- R11: A frame whose byte count does not fit the current mode (for example an AFh data-only frame outside the mode, or an AFh frame with two data bytes inside it) is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csn | input | 1 | Chip select, active low, synchronous to clk |
| sck | input | 1 | Serial clock, synchronous to clk |
| mosi | input | 1 | Serial data into the device |
| miso | output | 1 | Serial data out of the device (status) |
| top_addr | input | ADDR_W | Highest unprotected address |
| prog_cycles | input | CNT_W | Program cycle length in clocks |
| busy | output | 1 | Program cycle in progress |
| mem_we | output | 1 | Byte write request to the array |
| mem_addr | output | ADDR_W | Write address |
| mem_wdata | output | 8 | Value to store (old AND new) |
| mem_rdata | input | 8 | Current array content at `mem_addr` |

## Verification
The assertions assume that `top_addr` and `prog_cycles` stay constant while a program sequence is in flight. They also assume that `prog_cycles` is at least one and that the serial inputs change only between clock edges, with each SCK phase lasting several clocks. The bench sets both configuration inputs once before reset is released. It drives every serial input on the falling clock edge and holds each SCK level for four clocks. This means the edge detector sees every transition exactly once, and the 300-clock program time is long enough for a program frame sent straight after another one to land while busy.

// File: rtl/aai_pkg.sv
package aai_pkg;

  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_AAI  = 8'hAF;

  localparam int ST_BUSY_BIT = 0;
  localparam int ST_WEL_BIT  = 1;

  typedef enum logic [2:0] {
    FR_NONE,
    FR_WREN,
    FR_WRDI,
    FR_AAI_FIRST,
    FR_AAI_NEXT
  } frame_kind_e;

endpackage

// File: rtl/aai_spi_shifter.sv
module aai_spi_shifter
  import aai_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csn,
  input  logic             sck,
  input  logic             mosi,
  input  logic [7:0]       status,
  output logic             byte_vld,
  output logic [7:0]       byte_val,
  output logic [IDX_W-1:0] byte_idx,
  output logic             frame_end,
  output logic             frame_partial,
  output logic [IDX_W-1:0] frame_bytes,
  output logic             miso
);

  localparam logic [IDX_W-1:0] CNT_MAX = '1;

  logic             csn_q, sck_q;
  logic [2:0]       bit_q, bit_d;
  logic [IDX_W-1:0] cnt_q, cnt_d;
  logic [6:0]       sh_q, sh_d;
  logic [7:0]       op_q, op_d;
  logic [7:0]       out_q, out_d;
  logic             sck_rise, sck_fall, rd_active;

  assign sck_rise  = sck & ~sck_q & ~csn;
  assign sck_fall  = ~sck & sck_q & ~csn;
  assign frame_end = csn & ~csn_q;
  assign rd_active = (cnt_q != '0) && (op_q == OP_RDSR);

  assign byte_vld      = sck_rise && (bit_q == 3'd7);
  assign byte_val      = {sh_q, mosi};
  assign byte_idx      = cnt_q;
  assign frame_partial = (bit_q != 3'd0);
  assign frame_bytes   = cnt_q;
  assign miso          = rd_active & out_q[7];

  always_comb begin
    bit_d = bit_q;
    cnt_d = cnt_q;
    sh_d  = sh_q;
    op_d  = op_q;
    out_d = out_q;
    if (csn) begin
      bit_d = 3'd0;
      cnt_d = '0;
    end else if (sck_rise) begin
      sh_d  = {sh_q[5:0], mosi};
      bit_d = bit_q + 3'd1;
      if (bit_q == 3'd7) begin
        if (cnt_q != CNT_MAX) cnt_d = cnt_q + IDX_W'(1);
        if (cnt_q == '0)      op_d  = {sh_q, mosi};
      end
    end
    if (sck_fall && rd_active) begin
      if (bit_q == 3'd0) out_d = status;
      else               out_d = {out_q[6:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csn_q <= 1'b1;
      sck_q <= 1'b0;
      bit_q <= 3'd0;
      cnt_q <= '0;
      sh_q  <= '0;
      op_q  <= '0;
      out_q <= '0;
    end else begin
      csn_q <= csn;
      sck_q <= sck;
      bit_q <= bit_d;
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
      op_q  <= op_d;
      out_q <= out_d;
    end
  end

  // R9
  frame_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (frame_bytes == '0) && !frame_partial);

endmodule

// File: rtl/aai_cmd_ctrl.sv
module aai_cmd_ctrl
  import aai_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld,
  input  logic [7:0]        byte_val,
  input  logic [IDX_W-1:0]  byte_idx,
  input  logic              frame_end,
  input  logic              frame_partial,
  input  logic [IDX_W-1:0]  frame_bytes,
  input  logic              busy,
  input  logic [ADDR_W-1:0] top_addr,
  output logic              wel,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data
);

  localparam int               ADDR_BYTES = ADDR_W / 8;
  localparam logic [IDX_W-1:0] FIRST_LEN  = IDX_W'(ADDR_BYTES + 2);
  localparam logic [IDX_W-1:0] NEXT_LEN   = IDX_W'(2);

  logic [7:0]        cmd_q, cmd_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [7:0]        data_q, data_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic              mode_q, mode_d;
  logic              wel_q, wel_d;
  logic              wr_req_q, wr_req_d;
  logic [ADDR_W-1:0] wr_addr_q, wr_addr_d;
  logic [7:0]        wr_data_q, wr_data_d;
  logic [ADDR_W-1:0] tgt;
  frame_kind_e       kind;

  // byte capture
  always_comb begin
    cmd_d  = cmd_q;
    addr_d = addr_q;
    data_d = data_q;
    if (byte_vld) begin
      if (byte_idx == '0) begin
        cmd_d = byte_val;
      end else begin
        data_d = byte_val;
        if (byte_idx <= IDX_W'(ADDR_BYTES))
          addr_d = {addr_q[ADDR_W-9:0], byte_val};
      end
    end
  end

  // frame classification at chip-select release
  always_comb begin
    kind = FR_NONE;
    if (frame_end && !frame_partial) begin
      if (frame_bytes == IDX_W'(1) && cmd_q == OP_WREN) begin
        kind = FR_WREN;
      end else if (frame_bytes == IDX_W'(1) && cmd_q == OP_WRDI) begin
        kind = FR_WRDI;
      end else if (cmd_q == OP_AAI && wel_q && !busy && !wr_req_q) begin
        if (mode_q && frame_bytes == NEXT_LEN)
          kind = FR_AAI_NEXT;
        else if (!mode_q && frame_bytes == FIRST_LEN && addr_q <= top_addr)
          kind = FR_AAI_FIRST;
      end
    end
  end

  assign tgt = (kind == FR_AAI_FIRST) ? addr_q : ptr_q;

  always_comb begin
    ptr_d     = ptr_q;
    mode_d    = mode_q;
    wel_d     = wel_q;
    wr_req_d  = 1'b0;
    wr_addr_d = wr_addr_q;
    wr_data_d = wr_data_q;
    case (kind)
      FR_WREN: wel_d = 1'b1;
      FR_WRDI: begin
        wel_d  = 1'b0;
        mode_d = 1'b0;
      end
      FR_AAI_FIRST, FR_AAI_NEXT: begin
        wr_req_d  = 1'b1;
        wr_addr_d = tgt;
        wr_data_d = data_q;
        if (tgt == top_addr) begin
          mode_d = 1'b0;
          wel_d  = 1'b0;
        end else begin
          mode_d = 1'b1;
          ptr_d  = tgt + ADDR_W'(1);
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q     <= '0;
      addr_q    <= '0;
      data_q    <= '0;
      ptr_q     <= '0;
      mode_q    <= 1'b0;
      wel_q     <= 1'b0;
      wr_req_q  <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else begin
      cmd_q     <= cmd_d;
      addr_q    <= addr_d;
      data_q    <= data_d;
      ptr_q     <= ptr_d;
      mode_q    <= mode_d;
      wel_q     <= wel_d;
      wr_req_q  <= wr_req_d;
      wr_addr_q <= wr_addr_d;
      wr_data_q <= wr_data_d;
    end
  end

  assign wel     = wel_q;
  assign wr_req  = wr_req_q;
  assign wr_addr = wr_addr_q;
  assign wr_data = wr_data_q;

  // R1
  wel_before_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req_q |-> $past(wel_q));

  // R7
  write_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req_q |-> (wr_addr_q <= top_addr));

  // R7
  ptr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q |-> (ptr_q <= top_addr));

  // R5
  wrdi_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !frame_partial && frame_bytes == IDX_W'(1) && cmd_q == OP_WRDI)
    |=> (!wel_q && !mode_q));

  // R9
  no_write_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !wr_req_q);

endmodule

// File: rtl/aai_prog_timer.sv
module aai_prog_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] prog_cycles,
  output logic             busy
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start)               cnt_d = prog_cycles;
    else if (cnt_q != '0)    cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);

  // R4
  busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  // R4
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(cnt_q) == CNT_W'(1)));

  // R9
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);

endmodule

// File: rtl/aai_flash_ctrl.sv
module aai_flash_ctrl
  import aai_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csn,
  input  logic              sck,
  input  logic              mosi,
  output logic              miso,
  input  logic [ADDR_W-1:0] top_addr,
  input  logic [CNT_W-1:0]  prog_cycles,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata
);

  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam int IDX_W      = $clog2(ADDR_BYTES + 3);

  logic             byte_vld, frame_end, frame_partial;
  logic [7:0]       byte_val;
  logic [IDX_W-1:0] byte_idx, frame_bytes;
  logic [7:0]       status;
  logic             wel, wr_req, busy_w;
  logic [7:0]       wr_data;

  always_comb begin
    status              = '0;
    status[ST_BUSY_BIT] = busy_w;
    status[ST_WEL_BIT]  = wel;
  end

  aai_spi_shifter #(.IDX_W(IDX_W)) shifter_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .csn          (csn),
    .sck          (sck),
    .mosi         (mosi),
    .status       (status),
    .byte_vld     (byte_vld),
    .byte_val     (byte_val),
    .byte_idx     (byte_idx),
    .frame_end    (frame_end),
    .frame_partial(frame_partial),
    .frame_bytes  (frame_bytes),
    .miso         (miso)
  );

  aai_cmd_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) ctrl_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .byte_vld     (byte_vld),
    .byte_val     (byte_val),
    .byte_idx     (byte_idx),
    .frame_end    (frame_end),
    .frame_partial(frame_partial),
    .frame_bytes  (frame_bytes),
    .busy         (busy_w),
    .top_addr     (top_addr),
    .wel          (wel),
    .wr_req       (wr_req),
    .wr_addr      (mem_addr),
    .wr_data      (wr_data)
  );

  aai_prog_timer #(.CNT_W(CNT_W)) timer_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (wr_req),
    .prog_cycles(prog_cycles),
    .busy       (busy_w)
  );

  assign busy      = busy_w;
  assign mem_we    = wr_req;
  assign mem_wdata = mem_rdata & wr_data;

  // R10
  and_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ((mem_wdata & ~mem_rdata) == 8'h00));

endmodule

// File: tb/aai_flash_ctrl_tb_top.sv
module aai_flash_ctrl_tb_top;

  localparam int AW   = 24;
  localparam int CW   = 16;
  localparam int PROG = 300;

  logic          clk, rst_n, csn, sck, mosi, miso, busy, mem_we;
  logic [AW-1:0] top_addr, mem_addr;
  logic [CW-1:0] prog_cycles;
  logic [7:0]    mem_wdata, mem_rdata;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  typedef struct {
    logic [AW-1:0] a;
    logic [7:0]    d;
    string         req;
  } exp_t;
  exp_t expq[$];

  logic [7:0] mem    [0:255];
  logic [7:0] shadow [0:255];

  aai_flash_ctrl #(.ADDR_W(AW), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .csn(csn), .sck(sck), .mosi(mosi), .miso(miso),
    .top_addr(top_addr), .prog_cycles(prog_cycles), .busy(busy),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // behavioural array
  assign mem_rdata = mem[mem_addr[7:0]];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'hFF;
    end else if (mem_we) begin
      mem[mem_addr[7:0]] <= mem_wdata;
    end
  end

  // scoreboard monitor: writes
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      total++;
      if (expq.size() == 0) begin
        bad++;
        $display("FAIL R1/R6/R9/R11 unexpected write: addr=%h data=%h expected none",
                 mem_addr, mem_wdata);
      end else begin
        exp_t e;
        e = expq.pop_front();
        if (mem_addr !== e.a || mem_wdata !== e.d) begin
          bad++;
          $display("FAIL %s write: addr=%h data=%h expected addr=%h data=%h",
                   e.req, mem_addr, mem_wdata, e.a, e.d);
        end
      end
    end
  end

  // monitor: busy length and its start after each write (R4)
  int  run_len = 0;
  bit  prev_we = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_we) begin
        total++;
        if (busy !== 1'b1) begin
          bad++;
          $display("FAIL R4 busy after write: actual=%b expected=1", busy);
        end
      end
      prev_we = mem_we;
      if (busy) begin
        run_len++;
      end else if (run_len != 0) begin
        total++;
        if (run_len != PROG) begin
          bad++;
          $display("FAIL R4 busy length: actual=%0d expected=%0d", run_len, PROG);
        end
        run_len = 0;
      end
    end
  end

  task automatic expect_write(input logic [AW-1:0] a, input logic [7:0] d,
                              input string req);
    exp_t e;
    shadow[a[7:0]] = shadow[a[7:0]] & d;
    e.a = a;
    e.d = shadow[a[7:0]];
    e.req = req;
    expq.push_back(e);
  endtask

  task automatic half_phase();
    repeat (4) @(negedge clk);
  endtask

  task automatic cs_begin();
    @(negedge clk);
    csn = 1'b0;
    half_phase();
  endtask

  task automatic cs_end();
    half_phase();
    csn = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic xfer_bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 7; i > 7 - n; i--) begin
      @(negedge clk);
      mosi = tx[i];
      half_phase();
      rx[i] = miso;
      sck = 1'b1;
      half_phase();
      sck = 1'b0;
    end
  endtask

  task automatic send_cmd(input logic [7:0] op);
    logic [7:0] rx;
    cs_begin();
    xfer_bits(op, 8, rx);
    cs_end();
  endtask

  task automatic aai_first(input logic [AW-1:0] a, input logic [7:0] d);
    logic [7:0] rx;
    cs_begin();
    xfer_bits(8'hAF, 8, rx);
    xfer_bits(a[23:16], 8, rx);
    xfer_bits(a[15:8], 8, rx);
    xfer_bits(a[7:0], 8, rx);
    xfer_bits(d, 8, rx);
    cs_end();
  endtask

  task automatic aai_next(input logic [7:0] d);
    logic [7:0] rx;
    cs_begin();
    xfer_bits(8'hAF, 8, rx);
    xfer_bits(d, 8, rx);
    cs_end();
  endtask

  task automatic check_status(input logic [7:0] exp, input string req);
    logic [7:0] r0, r1, r2;
    cs_begin();
    xfer_bits(8'h05, 8, r0);
    xfer_bits(8'h00, 8, r1);
    xfer_bits(8'h00, 8, r2);
    cs_end();
    total++;
    if (r1 !== exp || r2 !== exp) begin
      bad++;
      $display("FAIL %s status: actual=%h/%h expected=%h", req, r1, r2, exp);
    end
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(negedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    csn = 1'b1;
    sck = 1'b0;
    mosi = 1'b0;
    top_addr = 24'h000040;
    prog_cycles = CW'(PROG);
    for (int i = 0; i < 256; i++) shadow[i] = 8'hFF;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // reset state
    total++;
    if (busy !== 1'b0 || mem_we !== 1'b0 || miso !== 1'b0) begin
      bad++;
      $display("FAIL R4/R8 reset: busy=%b we=%b miso=%b expected 0 0 0", busy, mem_we, miso);
    end
    check_status(8'h00, "R8");

    // R1: program without latch is ignored
    aai_first(24'h000010, 8'h11);
    wait_idle();
    check_status(8'h00, "R1");
    send_cmd(8'h06);
    check_status(8'h02, "R1");

    // R2 first frame, R8 status while busy
    expect_write(24'h000010, 8'hA5, "R2");
    aai_first(24'h000010, 8'hA5);
    check_status(8'h03, "R8");
    wait_idle();
    check_status(8'h02, "R8");

    // R3 next address, R9 frame while busy dropped
    expect_write(24'h000011, 8'h3C, "R3");
    aai_next(8'h3C);
    aai_next(8'h77);
    wait_idle();

    // R9 partial frame dropped, pointer kept
    begin
      logic [7:0] rx;
      cs_begin();
      xfer_bits(8'hAF, 8, rx);
      xfer_bits(8'h12, 5, rx);
      cs_end();
    end
    expect_write(24'h000012, 8'h5A, "R9");
    aai_next(8'h5A);
    wait_idle();

    // R11 wrong length in mode
    begin
      logic [7:0] rx;
      cs_begin();
      xfer_bits(8'hAF, 8, rx);
      xfer_bits(8'h01, 8, rx);
      xfer_bits(8'h02, 8, rx);
      cs_end();
    end
    expect_write(24'h000013, 8'h66, "R11");
    aai_next(8'h66);
    wait_idle();

    // R5 write disable ends mode
    send_cmd(8'h04);
    check_status(8'h00, "R5");
    send_cmd(8'h06);
    aai_next(8'h99);
    wait_idle();
    check_status(8'h02, "R5");

    // R10 AND programming
    expect_write(24'h000010, 8'h0F, "R10");
    aai_first(24'h000010, 8'h0F);
    wait_idle();
    expect_write(24'h000011, 8'hF0, "R10");
    aai_next(8'hF0);
    wait_idle();
    send_cmd(8'h04);

    // R6 protected start
    send_cmd(8'h06);
    aai_first(24'h000041, 8'h12);
    wait_idle();
    check_status(8'h02, "R6");
    aai_next(8'h34);
    wait_idle();
    check_status(8'h02, "R6");

    // R7 end at boundary
    expect_write(24'h00003F, 8'hC3, "R2");
    aai_first(24'h00003F, 8'hC3);
    wait_idle();
    expect_write(24'h000040, 8'h81, "R7");
    aai_next(8'h81);
    wait_idle();
    check_status(8'h00, "R7");
    send_cmd(8'h06);
    aai_next(8'h22);
    wait_idle();
    check_status(8'h02, "R7");

    // R7 start exactly at boundary
    expect_write(24'h000040, 8'h7E, "R7");
    aai_first(24'h000040, 8'h7E);
    wait_idle();
    check_status(8'h00, "R7");

    // all expected writes seen (R3)
    repeat (10) @(negedge clk);
    total++;
    if (expq.size() != 0) begin
      bad++;
      $display("FAIL R3 missing writes: actual=%0d pending expected=0", expq.size());
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule